// File: doc/BRIEF.md
# Single-Mask Element Step Sequencer

This block walks the element positions of a vector operation in which one predicate mask governs every operand. A start pulse latches a vector length, the mask and two zeroing enables, one for the source side and one for the destination side. The block then presents one (source index, destination index) pair per accepted handshake. With each pair it gives two flags: one says the source element reads as zero, the other says the destination element is written with zero.

Each side keeps its own position. A side with zeroing disabled jumps, within one cycle, to the next position whose mask bit is set. A side with zeroing enabled visits every position in turn and raises its zero flag where the mask bit is clear. Both positions advance on every accepted pair. When the two enables are equal, the indices therefore stay locked together. When they differ, the indices drift apart.

The run ends after the latched vector length of pairs has been accepted, or earlier when a skipping side finds no set mask bit at or above its position. A one-cycle done pulse marks the end.

Top module: `spred_step_seq`

## Requirements
- R1: After reset, valid_o, done_o and busy_o are 0.
- R2: start_i is taken only while busy_o is 0. The block then latches vl_i (values above MASK_W are clamped to MASK_W), mask_i, src_zero_en_i and dst_zero_en_i, and resets both positions to 0. A start_i pulse while busy_o is 1 has no effect on the running sequence, and later changes to the inputs have no effect either.
- R3: Each accepted pair (valid_o and ready_i high at a clock edge) advances both sides. The next pair presented has a source index strictly above the previous one, and a destination index strictly above the previous one.
- R4: When the two zeroing enables are equal, src_idx_o equals dst_idx_o on every presented pair.
- R5: A side with zeroing disabled presents the lowest index whose mask bit (bit i of mask_i governs element i) is 1, taken from at or above its position. Its zero flag is 0.
- R6: A side with zeroing enabled presents its position, which equals the number of pairs already accepted. Its zero flag is 1 exactly when that position's mask bit is 0.
- R7: With VL=3, mask 0b1101, source zeroing on and destination zeroing off, the pairs are (0,0), (1,2), (2,3).
- R8: When VL pairs have been accepted, valid_o stays 0. done_o pulses high for exactly one cycle, and busy_o returns to 0 in the same cycle.
- R9: If a skipping side has no set mask bit left at or above its position, the run ends with a done pulse and no further pair is presented.
- R10: VL=0 produces a done pulse with no pair presented.
- R11: While valid_o is 1 and ready_i is 0, the presented pair and its flags stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a run (ignored while busy) |
| vl_i | input | $clog2(MASK_W+1) | Vector length |
| mask_i | input | MASK_W | Predicate mask, bit i for element i |
| src_zero_en_i | input | 1 | Source zeroing enable |
| dst_zero_en_i | input | 1 | Destination zeroing enable |
| ready_i | input | 1 | Consumer accepts the presented pair |
| valid_o | output | 1 | A pair is presented |
| src_idx_o | output | $clog2(MASK_W) | Source element index |
| dst_idx_o | output | $clog2(MASK_W) | Destination element index |
| src_zero_o | output | 1 | Source element reads as zero |
| dst_zero_o | output | 1 | Destination element is written with zero |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is a run that ends early because a skipping side runs out of set mask bits while the zeroing side still has steps left. That needs a sparse mask, unequal zeroing enables and a VL larger than the number of set bits. The random runs draw masks from several densities, including masks with only a few bits set, and directed runs cover an empty mask and the documented divergent example. Random back-pressure on ready_i and start pulses sent in the middle of a run, with the inputs scrambled, show that stalled pairs hold steady and that the latched state is left alone.

// File: rtl/spred_pkg.sv
package spred_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } seq_state_e;
endpackage

// File: rtl/spred_find_first.sv
// Lowest set mask bit at or above from_i.
module spred_find_first #(
  parameter int MASK_W = 64,
  localparam int CW = $clog2(MASK_W + 1),
  localparam int IW = $clog2(MASK_W)
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic [CW-1:0]     from_i,
  output logic              found_o,
  output logic [IW-1:0]     idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (!found_o && mask_i[i] && (CW'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spred_lane.sv
// One side (source or destination) of the step pair.
module spred_lane #(
  parameter int MASK_W = 64,
  localparam int CW = $clog2(MASK_W + 1),
  localparam int IW = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              zero_en_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              avail_o,
  output logic [IW-1:0]     idx_o,
  output logic              zero_o
);
  logic [CW-1:0] pos_q;
  logic          ff_found;
  logic [IW-1:0] ff_idx;

  spred_find_first #(.MASK_W(MASK_W)) u_ff (
    .mask_i (mask_i),
    .from_i (pos_q),
    .found_o(ff_found),
    .idx_o  (ff_idx)
  );

  always_comb begin
    if (zero_en_i) begin
      avail_o = pos_q < CW'(MASK_W);
      idx_o   = IW'(pos_q);
      zero_o  = !mask_i[IW'(pos_q)];
    end else begin
      avail_o = ff_found;
      idx_o   = ff_idx;
      zero_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (init_i) pos_q <= '0;
    else if (step_i) pos_q <= CW'(idx_o) + CW'(1);
  end
endmodule

// File: rtl/spred_step_seq.sv
module spred_step_seq
  import spred_pkg::*;
#(
  parameter int MASK_W = 64,
  localparam int CW = $clog2(MASK_W + 1),
  localparam int IW = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CW-1:0]     vl_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              src_zero_en_i,
  input  logic              dst_zero_en_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [IW-1:0]     src_idx_o,
  output logic [IW-1:0]     dst_idx_o,
  output logic              src_zero_o,
  output logic              dst_zero_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e        state_q;
  logic [CW-1:0]     vl_q, cnt_q;
  logic [MASK_W-1:0] mask_q;
  logic              sz_q, dz_q, done_q;
  logic              take, fire, end_c;
  logic              src_avail, dst_avail;

  assign busy_o = (state_q == ST_BUSY);
  assign take   = start_i && !busy_o;
  assign end_c  = busy_o && ((cnt_q == vl_q) || !src_avail || !dst_avail);
  assign valid_o = busy_o && !end_c;
  assign fire   = valid_o && ready_i;
  assign done_o = done_q;

  spred_lane #(.MASK_W(MASK_W)) u_src (
    .clk_i, .rst_ni,
    .init_i   (take),
    .step_i   (fire),
    .zero_en_i(sz_q),
    .mask_i   (mask_q),
    .avail_o  (src_avail),
    .idx_o    (src_idx_o),
    .zero_o   (src_zero_o)
  );

  spred_lane #(.MASK_W(MASK_W)) u_dst (
    .clk_i, .rst_ni,
    .init_i   (take),
    .step_i   (fire),
    .zero_en_i(dz_q),
    .mask_i   (mask_q),
    .avail_o  (dst_avail),
    .idx_o    (dst_idx_o),
    .zero_o   (dst_zero_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      sz_q    <= 1'b0;
      dz_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        state_q <= ST_BUSY;
        vl_q    <= (vl_i > CW'(MASK_W)) ? CW'(MASK_W) : vl_i;
        mask_q  <= mask_i;
        sz_q    <= src_zero_en_i;
        dz_q    <= dst_zero_en_i;
        cnt_q   <= '0;
      end else if (end_c) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else if (fire) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R4: equal zeroing enables keep indices locked
  a_r4_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (sz_q == dz_q)) |-> (src_idx_o == dst_idx_o));
  // R3: both indices move up after an accepted pair
  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (!valid_o || ((src_idx_o > $past(src_idx_o)) && (dst_idx_o > $past(dst_idx_o)))));
  // R5: a skipping side only lands on set mask bits
  a_r5_src_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !sz_q) |-> (mask_q[src_idx_o] && !src_zero_o));
  a_r5_dst_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !dz_q) |-> (mask_q[dst_idx_o] && !dst_zero_o));
  // R11: stalled pair holds
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(src_idx_o) && $stable(dst_idx_o)
                               && $stable(src_zero_o) && $stable(dst_zero_o)));
  // R8: done is a single-cycle pulse with nothing presented
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!valid_o && !busy_o));
  // R6: zeroing side count never exceeds VL
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= vl_q));
endmodule

// File: tb/tb_spred_step_seq.sv
module tb_spred_step_seq;
  localparam int MASK_W = 64;
  localparam int CW = $clog2(MASK_W + 1);
  localparam int IW = $clog2(MASK_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [CW-1:0]     vl_i = '0;
  logic [MASK_W-1:0] mask_i = '0;
  logic              sz_i = 1'b0, dz_i = 1'b0, ready_i = 1'b0;
  logic              valid_o, src_zero_o, dst_zero_o, busy_o, done_o;
  logic [IW-1:0]     src_idx_o, dst_idx_o;

  int checks = 0, fails = 0;
  int rec_src[0:127];
  int rec_dst[0:127];
  int npairs;

  always #4 clk = ~clk;

  spred_step_seq #(.MASK_W(MASK_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vl_i(vl_i), .mask_i(mask_i),
    .src_zero_en_i(sz_i), .dst_zero_en_i(dz_i), .ready_i(ready_i),
    .valid_o(valid_o), .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
    .src_zero_o(src_zero_o), .dst_zero_o(dst_zero_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // next set bit at or above p, -1 if none
  function automatic int next_set(input logic [MASK_W-1:0] m, input int p);
    for (int i = p; i < MASK_W; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic run(input int vl, input logic [MASK_W-1:0] m, input bit sz, input bit dz,
                     input bit stall, input bit restart);
    int ms = 0, md = 0, mc = 0, es, ed, guard;
    bit ez, zs, zd, seen_done = 0;
    int evl;
    evl = (vl > MASK_W) ? MASK_W : vl;
    npairs = 0;
    @(negedge clk);
    vl_i = CW'(vl); mask_i = m; sz_i = sz; dz_i = dz; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    vl_i = CW'($urandom_range(0, MASK_W)); mask_i = {$urandom, $urandom};
    sz_i = $urandom; dz_i = $urandom;
    #1 chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    for (guard = 0; guard < 2000; guard++) begin
      ready_i = stall ? 1'($urandom % 2) : 1'b1;
      start_i = (restart && guard == 3);
      #1;
      es = sz ? ms : next_set(m, ms);
      ed = dz ? md : next_set(m, md);
      ez = (mc >= evl) || (es < 0) || (ed < 0);
      if (done_o) begin
        chk(ez, "R8/R9/R10 done at end", mc, evl);
        seen_done = 1;
        break;
      end
      if (ez) begin
        chk(!valid_o, "R8/R9 no pair after end", valid_o, 0);
      end else begin
        zs = sz && !m[es];
        zd = dz && !m[ed];
        chk(valid_o, "R3 pair presented", valid_o, 1);
        chk(src_idx_o == IW'(es), (sz ? "R6 src idx" : "R5 src idx"), src_idx_o, es);
        chk(dst_idx_o == IW'(ed), (dz ? "R6 dst idx" : "R5 dst idx"), dst_idx_o, ed);
        chk(src_zero_o == zs, "R6 src zero flag", src_zero_o, zs);
        chk(dst_zero_o == zd, "R6 dst zero flag", dst_zero_o, zd);
        if (sz == dz) chk(src_idx_o == dst_idx_o, "R4 locked", src_idx_o, dst_idx_o);
        if (valid_o && ready_i) begin
          rec_src[npairs] = es; rec_dst[npairs] = ed; npairs++;
          ms = es + 1; md = ed + 1; mc++;
        end
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(seen_done, "R8 done seen", seen_done, 1);
    chk(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
    @(negedge clk);
    #1 chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    chk(valid_o == 1'b0, "R8 idle after done", valid_o, 0);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    #3;
    chk(valid_o == 0 && done_o == 0 && busy_o == 0, "R1 reset outputs",
        {valid_o, done_o, busy_o}, 0);
    #20 rst_n = 1'b1;

    // R7 divergent example
    run(3, 64'b1101, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(npairs == 3, "R7 pair count", npairs, 3);
    chk(rec_src[0] == 0 && rec_dst[0] == 0, "R7 pair0", rec_src[0]*100 + rec_dst[0], 0);
    chk(rec_src[1] == 1 && rec_dst[1] == 2, "R7 pair1", rec_src[1]*100 + rec_dst[1], 102);
    chk(rec_src[2] == 2 && rec_dst[2] == 3, "R7 pair2", rec_src[2]*100 + rec_dst[2], 203);

    // R10 VL zero
    run(0, '1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(npairs == 0, "R10 no pairs", npairs, 0);
    // R9 empty mask with skipping side
    run(10, '0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(npairs == 0, "R9 empty mask no pairs", npairs, 0);
    // R9 sparse early exhaustion
    run(20, 64'h0000_0000_0000_0104, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(npairs == 2, "R9 sparse pairs", npairs, 2);
    // full length, all ones
    run(64, '1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(npairs == 64, "R8 full length", npairs, 64);
    // R2 clamp of VL above width
    run(100, '1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(npairs == 64, "R2 VL clamp", npairs, 64);
    // R2 start while busy ignored
    run(12, 64'hF0F0_1234_5678_9ABC, 1'b1, 1'b1, 1'b1, 1'b1);
    chk(npairs == 12, "R2 restart ignored", npairs, 12);

    for (int t = 0; t < 40; t++) begin
      logic [MASK_W-1:0] m;
      int dens;
      dens = $urandom % 4;
      m = {$urandom, $urandom};
      if (dens == 0) m = m & {$urandom, $urandom} & {$urandom, $urandom};
      if (dens == 1) m = m | {$urandom, $urandom};
      if (dens == 2) m = MASK_W'(1) << ($urandom % MASK_W) | MASK_W'(1) << ($urandom % MASK_W);
      run($urandom_range(0, MASK_W), m, 1'($urandom), 1'($urandom), 1'b1, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule